// File: doc/BRIEF.md
# Carry-Skip Group Adder

This block adds two unsigned operands and a carry-in in a single combinational pass. It returns a sum as wide as the operands, plus a carry-out. The operand width is divided into equal groups, four bits each by default. Inside a group the carry moves one bit at a time. Each bit's carry is formed from that bit's generate term (both operand bits high) and its propagate term (operand bits differ).

Every group also has a skip multiplexer. When all propagate terms of a group are high, the group forwards its incoming carry straight to its outgoing carry and does not wait for its own chain. Otherwise the group's chain output is used, and that output has been settled by a kill or a generate inside the group. The carry-out of the whole adder is the output of the last group's multiplexer. The block has no clock and no state, so it is meant to sit between registers of the surrounding datapath.

Top module: `cba_adder16`

## Requirements
- R1: For every input, {carry_out, sum_o} equals the arithmetic sum op_a + op_b + carry_in, taken over WIDTH+1 bits.
- R2: When op_a XOR op_b is all ones, sum_o equals every bit set to NOT carry_in, and carry_out equals carry_in.
- R3: When the bits of group k (bits 4k to 4k+3) all differ between op_a and op_b, the carry leaving group k equals the carry entering it. For k < 3 this is seen as sum_o[4k+4] = op_a[4k+4] ^ op_b[4k+4] ^ carry-into-group-k.
- R4: When op_a[4k+3] and op_b[4k+3] are both 1, the carry leaving group k is 1. It is seen in sum_o[4k+4] for k < 3 and in carry_out for k = 3.
- R5: When op_a[4k+3] and op_b[4k+3] are both 0, the carry leaving group k is 0. It is seen in the same places as in R4.
- R6: When group 3 (bits 12 to 15) fully propagates, carry_out equals the carry into bit 12, that is bit 12 of op_a[11:0] + op_b[11:0] + carry_in.
- R7: The outputs depend only on the present inputs. A result sampled in the same cycle its inputs were applied is correct, whatever the previous inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of the top group's skip multiplexer |

## Verification
The hardest case to reach is a skip path that decides the result. Random operands make a group fully propagate only once in sixteen tries, and they almost never chain several such groups together. The stimulus therefore builds operands in which a chosen group holds complementary bit pairs, with the other groups random, and applies each with both carry-in values. It adds operands that propagate across all sixteen bits, and operands whose top bit in each group generates or kills, so that each group's outgoing carry can be observed through the next group's lowest sum bit.

// File: rtl/cba_pkg.sv
// Package: shared types for the carry-skip adder.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package cba_pkg;

    // Per-bit carry classification.
    typedef struct packed {
        logic gen;   // both operand bits high
        logic prop;  // operand bits differ
        logic kill;  // both operand bits low
    } bit_class_t;

endpackage

// File: rtl/cba_bitcell.sv
// Module: cba_bitcell
// Classifies one operand bit pair as generate, propagate or kill.
// Assumes: exactly one of the three outputs is high for known inputs.
module cba_bitcell
    import cba_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    output bit_class_t cls_o
);

    // Form the three classification terms.
    always_comb begin
        cls_o.gen  = a_i & b_i;
        cls_o.prop = a_i ^ b_i;
        cls_o.kill = ~a_i & ~b_i;
    end

endmodule

// File: rtl/cba_group.sv
// Module: cba_group
// One carry group: a chain that settles the carry bit by bit, plus a skip
// multiplexer that forwards the incoming carry when every bit propagates.
// Assumes: GRP >= 1; purely combinational.
module cba_group
    import cba_pkg::*;
#(
    parameter int GRP = 4
) (
    input  logic [GRP-1:0] a_i,
    input  logic [GRP-1:0] b_i,
    input  logic           cin_i,
    output logic [GRP-1:0] sum_o,
    output logic           cout_o
);

    bit_class_t       cls [GRP];
    logic [GRP-1:0]   gen_v;
    logic [GRP-1:0]   prop_v;
    logic [GRP-1:0]   kill_v;
    logic [GRP:0]     chain;
    logic             skip;

    // One classification cell per bit.
    for (genvar i = 0; i < GRP; i++) begin : g_cell
        cba_bitcell u_cell (
            .a_i   (a_i[i]),
            .b_i   (b_i[i]),
            .cls_o (cls[i])
        );
        assign gen_v[i]  = cls[i].gen;
        assign prop_v[i] = cls[i].prop;
        assign kill_v[i] = cls[i].kill;
    end

    // Carry chain settled bit by bit from the group's carry-in.
    always_comb begin
        chain[0] = cin_i;
        for (int i = 0; i < GRP; i++) begin
            chain[i+1] = gen_v[i] | (prop_v[i] & chain[i]);
        end
    end

    // Skip select and output multiplexer.
    always_comb begin
        skip   = &prop_v;
        cout_o = skip ? cin_i : chain[GRP];
    end

    // Sum bits from propagate and the carry into each bit.
    always_comb begin
        sum_o = prop_v ^ chain[GRP-1:0];
    end

    // Skip path and chain must agree whenever the skip is taken.
    always_comb begin
        if (skip) begin
            assert_skip_matches_chain_R3: assert (chain[GRP] == cin_i)
                else $error("group skip disagrees with chain");
        end
    end

    // A generate at the top bit forces the carry out high.
    always_comb begin
        if (gen_v[GRP-1]) begin
            assert_top_gen_carry_R4: assert (cout_o == 1'b1)
                else $error("top generate did not produce carry");
        end
    end

    // A kill at the top bit forces the carry out low.
    always_comb begin
        if (kill_v[GRP-1]) begin
            assert_top_kill_carry_R5: assert (cout_o == 1'b0)
                else $error("top kill did not clear carry");
        end
    end

endmodule

// File: rtl/cba_adder16.sv
// Module: cba_adder16
// Top: WIDTH-bit combinational adder made of WIDTH/GRP carry-skip groups,
// carry passed from each group's skip multiplexer to the next group.
// Assumes: WIDTH is a multiple of GRP.
module cba_adder16 #(
    parameter int WIDTH = 16,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out
);

    localparam int NGRP = WIDTH / GRP;

    logic [NGRP:0] gcarry;

    // Parameter consistency.
    initial begin
        assert_width_divisible: assert (WIDTH % GRP == 0)
            else $error("WIDTH must be a multiple of GRP");
    end

    assign gcarry[0] = carry_in;

    // One group per GRP-bit slice, chained through the skip outputs.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cba_group #(.GRP(GRP)) u_grp (
            .a_i    (op_a[k*GRP +: GRP]),
            .b_i    (op_b[k*GRP +: GRP]),
            .cin_i  (gcarry[k]),
            .sum_o  (sum_o[k*GRP +: GRP]),
            .cout_o (gcarry[k+1])
        );
    end

    assign carry_out = gcarry[NGRP];

    // Full result against the arithmetic operator.
    always_comb begin
        assert_sum_exact_R1: assert ({carry_out, sum_o} ==
            ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("adder result mismatch");
    end

    // Whole-width propagate: every bit is the inverted carry-in.
    always_comb begin
        if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
            assert_full_propagate_R2: assert (sum_o == {WIDTH{~carry_in}}
                && carry_out == carry_in)
                else $error("full propagate result wrong");
        end
    end

endmodule

// File: tb/sim_cba_adder16.sv
// Bench for cba_adder16: behavioural reference compared on every clock.
module sim_cba_adder16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_o;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cba_adder16 u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_o     (sum_o),
        .carry_out (carry_out)
    );

    // Apply inputs at a falling edge, sample 1 ns later.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
    endtask

    // Full-result compare against integer arithmetic (R1, R7).
    task automatic check_full(input string tag);
        longint exp;
        longint got;
        exp = longint'(op_a) + longint'(op_b) + longint'(carry_in);
        got = {47'd0, carry_out, sum_o};
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h c=%0d got=%h exp=%h", tag, op_a, op_b, carry_in, got, exp);
        end
    endtask

    // Single-bit compare.
    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h c=%0d got=%0d exp=%0d", tag, op_a, op_b, carry_in, got, exp);
        end
    endtask

    // Carry into bit position pos, from integer arithmetic.
    function automatic logic carry_into(input logic [15:0] a, input logic [15:0] b,
                                        input logic c, input int pos);
        longint mask;
        longint s;
        mask = (longint'(1) << pos) - 1;
        s = (longint'(a) & mask) + (longint'(b) & mask) + longint'(c);
        return s[pos];
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [15:0] b;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: zero inputs give zero outputs (R1).
        apply(16'h0000, 16'h0000, 1'b0);
        check_full("R1 idle");
        check_bit("R1 idle cout", carry_out, 1'b0);

        // Full-width propagate, both carry-in values (R2).
        for (int c = 0; c < 2; c++) begin
            apply(16'hA5C3, 16'h5A3C, c[0]);
            checks++;
            if (sum_o !== {16{~c[0]}} || carry_out !== c[0]) begin
                errors++;
                $display("FAIL R2: got sum=%h cout=%0d exp sum=%h cout=%0d",
                         sum_o, carry_out, {16{~c[0]}}, c[0]);
            end
        end

        // Per-group skip path with random surroundings (R3, R6).
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 8; r++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [3:0] pat;
                    logic cin_g;
                    a = 16'($urandom);
                    b = 16'($urandom);
                    pat = 4'($urandom);
                    a[k*4 +: 4] = pat;
                    b[k*4 +: 4] = ~pat;
                    apply(a, b, c[0]);
                    check_full("R3 skip group");
                    cin_g = carry_into(a, b, c[0], k*4);
                    if (k < 3)
                        check_bit("R3 carry forwarded", sum_o[k*4+4], a[k*4+4] ^ b[k*4+4] ^ cin_g);
                    else
                        check_bit("R6 cout from top skip", carry_out, cin_g);
                end
            end
        end

        // Several groups propagating at once, carry chained through skips (R3).
        for (int c = 0; c < 2; c++) begin
            apply(16'h0F3C, 16'hF0C3 ^ 16'h000F, c[0]);
            check_full("R3 chained skips");
        end

        // Top-bit generate and kill per group (R4, R5).
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 2; c++) begin
                a = 16'($urandom); b = 16'($urandom);
                a[k*4+3] = 1'b1; b[k*4+3] = 1'b1;
                apply(a, b, c[0]);
                check_full("R4 generate");
                if (k < 3) check_bit("R4 gen carry", sum_o[k*4+4], a[k*4+4] ^ b[k*4+4] ^ 1'b1);
                else       check_bit("R4 gen cout", carry_out, 1'b1);

                a = 16'($urandom); b = 16'($urandom);
                a[k*4+3] = 1'b0; b[k*4+3] = 1'b0;
                apply(a, b, c[0]);
                check_full("R5 kill");
                if (k < 3) check_bit("R5 kill carry", sum_o[k*4+4], a[k*4+4] ^ b[k*4+4]);
                else       check_bit("R5 kill cout", carry_out, 1'b0);
            end
        end

        // Extremes (R1).
        apply(16'hFFFF, 16'hFFFF, 1'b1); check_full("R1 max");
        apply(16'hFFFF, 16'h0000, 1'b1); check_full("R1 wrap");
        apply(16'h8000, 16'h8000, 1'b0); check_full("R1 top carry");

        // Random sweep, new values each cycle (R1, R7).
        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom));
            check_full("R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule